// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block picks a sampling delay tap after a clock-phase sweep in which every tap was probed twice. It takes two result maps. The pass map records, for each probe, whether the command response was good. The compare map records, for each probe, whether the data comparator matched. Both maps hold 2·n probe bits, where n is the number of taps in use.

A start pulse begins a run. For each map, the block first makes the two probes of each tap agree: a tap counts as good only if both of its probes succeeded. It then scans the merged pass map one bit per clock and finds the longest run of consecutive passes. If every probe passed, it scans the merged compare map in the same way and uses that run instead. The block reports the tap at the centre of the chosen run, reduced modulo n. If no run qualifies, it raises an error flag.

A done pulse marks the result. The tap and error outputs then hold their values until the next accepted start.

Top module: `tap_window_sel`

## Requirements
- R1: Out of reset, done_o, err_o and tap_o are all 0.
- R2: Bit i of each map is probe i of tap (i mod n), and 1 means success. Tap k counts as good in a map only if bits k and k+n of that map are both 1. Otherwise both bits are treated as 0. Each map is merged on its own.
- R3: On success, tap_o = ((s + e) / 2) mod n, with integer division, where s and e are the first and last bit indices of the longest run of 1s in the merged map that is used.
- R4: A run that is still open at bit 2n-1 is considered like any other run. In particular, an all-ones map gives a run from 0 to 2n-1.
- R5: Among runs of equal length, the lowest-indexed one is used.
- R6: When the merged pass map is not all ones, the result succeeds only if its longest run is at least 3 bits long. Otherwise err_o = 1 and tap_o = 0.
- R7: When the merged pass map is all ones over 2n bits, the compare map's longest run is used. The result succeeds if that run is at least 1 bit long, and otherwise err_o = 1 and tap_o = 0.
- R8: A start with tap_cnt_i equal to 0 or greater than MAX_TAPS gives err_o = 1 and tap_o = 0.
- R9: done_o is high for exactly one cycle per accepted start. A start that arrives while a run is in progress is ignored. tap_o and err_o hold their values after done_o.
- R10: Map bits at index 2n and above have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| tap_cnt_i | input | $clog2(MAX_TAPS+1) | Number of taps n |
| pass_map_i | input | 2*MAX_TAPS | Command pass bit per probe |
| cmp_map_i | input | 2*MAX_TAPS | Data-compare match bit per probe |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | No usable tap found |
| tap_o | output | $clog2(MAX_TAPS) | Selected tap |

## Verification
Each pattern is chosen so that it separates one behaviour from the others.

- **Symmetric pass windows** produce two equal runs, which exposes the tie-break rule.
- **A window spanning the tap wrap** drives the centre index past n, which exercises the modulo reduction.
- **A map with one failed probe** yields a different tap depending on whether merging took place.
- **All-ones pass maps** send the selection to the compare map. Runs of length 0, 1 and several bits there separate the fallback rule from the minimum-length rule. Runs of length 2 and 3 in the pass map cover the minimum-length boundary itself.
- **Out-of-range tap counts** check that bad n values are rejected.
- **Junk above bit 2n** checks that unused map bits have no effect.
- **A second start sent mid-run** checks that it is ignored.

// File: rtl/tap_sel_pkg.sv
package tap_sel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_EVAL,
    ST_CMP,
    ST_DONE
  } sel_state_e;
endpackage

// File: rtl/tap_probe_merge.sv
module tap_probe_merge #(
  parameter int MAX_TAPS = 8,
  localparam int PW = 2 * MAX_TAPS,
  localparam int TW = $clog2(MAX_TAPS + 1),
  localparam int IW = $clog2(PW),
  localparam int CW = IW + 1
) (
  input  logic [PW-1:0] map_i,
  input  logic [TW-1:0] n_i,
  input  logic          n_ok_i,
  output logic [PW-1:0] map_o
);
  logic [CW-1:0] n_w, n2_w;
  assign n_w  = CW'(n_i);
  assign n2_w = n_w << 1;

  for (genvar g = 0; g < PW; g++) begin : g_bit
    logic [CW-1:0] up, dn;
    assign up = CW'(g) + n_w;
    assign dn = CW'(g) - n_w;
    always_comb begin
      map_o[g] = 1'b0;
      if (n_ok_i) begin
        if (CW'(g) < n_w)       map_o[g] = map_i[g] & map_i[up[IW-1:0]];
        else if (CW'(g) < n2_w) map_o[g] = map_i[g] & map_i[dn[IW-1:0]];
      end
    end
  end
endmodule

// File: rtl/tap_run_scan.sv
module tap_run_scan #(
  parameter int PW = 16,
  localparam int IW = $clog2(PW),
  localparam int LW = $clog2(PW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          bit_i,
  input  logic [IW-1:0] idx_i,
  output logic [LW-1:0] best_len_o,
  output logic [IW-1:0] best_start_o,
  output logic [IW-1:0] best_end_o
);
  logic [LW-1:0] cur_q, nxt_len;
  assign nxt_len = cur_q + LW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q        <= '0;
      best_len_o   <= '0;
      best_start_o <= '0;
      best_end_o   <= '0;
    end else if (clear_i) begin
      cur_q        <= '0;
      best_len_o   <= '0;
      best_start_o <= '0;
      best_end_o   <= '0;
    end else if (step_i) begin
      if (bit_i) begin
        cur_q <= nxt_len;
        // strictly longer only: earliest equal run is kept
        if (nxt_len > best_len_o) begin
          best_len_o   <= nxt_len;
          best_start_o <= idx_i - IW'(cur_q);
          best_end_o   <= idx_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  a_r5_best_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i) |=> best_len_o >= $past(best_len_o));
  a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    best_len_o <= LW'(PW) && best_end_o >= best_start_o);
endmodule

// File: rtl/tap_window_sel.sv
module tap_window_sel
  import tap_sel_pkg::*;
#(
  parameter int MAX_TAPS = 8,
  localparam int PW  = 2 * MAX_TAPS,
  localparam int TW  = $clog2(MAX_TAPS + 1),
  localparam int IW  = $clog2(PW),
  localparam int LW  = $clog2(PW + 1),
  localparam int TPW = $clog2(MAX_TAPS),
  localparam int MIN_RUN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [TW-1:0]  tap_cnt_i,
  input  logic [PW-1:0]  pass_map_i,
  input  logic [PW-1:0]  cmp_map_i,
  output logic           done_o,
  output logic           err_o,
  output logic [TPW-1:0] tap_o
);
  sel_state_e    state_q;
  logic [TW-1:0] n_q;
  logic [PW-1:0] shift_q, cmp_q;
  logic [IW-1:0] idx_q;
  logic          bad_q, cmp_phase_q;

  logic          n_ok, accept, full_run, scan_last, clear, step, ok;
  logic [PW-1:0] pass_m, cmp_m;
  logic [LW-1:0] best_len;
  logic [IW-1:0] best_start, best_end;
  logic [IW:0]   sum;
  logic [IW-1:0] mid, mid_mod;

  assign n_ok   = (tap_cnt_i != '0) && (int'(tap_cnt_i) <= MAX_TAPS);
  assign accept = (state_q == ST_IDLE) && start_i;

  tap_probe_merge #(.MAX_TAPS(MAX_TAPS)) u_merge_pass (
    .map_i(pass_map_i), .n_i(tap_cnt_i), .n_ok_i(n_ok), .map_o(pass_m));
  tap_probe_merge #(.MAX_TAPS(MAX_TAPS)) u_merge_cmp (
    .map_i(cmp_map_i), .n_i(tap_cnt_i), .n_ok_i(n_ok), .map_o(cmp_m));

  assign full_run  = best_len == (LW'(n_q) << 1);
  assign scan_last = idx_q == IW'((IW'(n_q) << 1) - IW'(1));
  assign clear     = accept || (state_q == ST_EVAL && full_run);
  assign step      = (state_q == ST_PASS) || (state_q == ST_CMP);

  tap_run_scan #(.PW(PW)) u_scan (
    .clk_i, .rst_ni,
    .clear_i(clear), .step_i(step), .bit_i(shift_q[0]), .idx_i(idx_q),
    .best_len_o(best_len), .best_start_o(best_start), .best_end_o(best_end));

  assign sum     = {1'b0, best_start} + {1'b0, best_end};
  assign mid     = sum[IW:1];
  assign mid_mod = (mid >= IW'(n_q)) ? mid - IW'(n_q) : mid;
  assign ok      = !bad_q && (cmp_phase_q ? (best_len != '0) : (best_len >= LW'(MIN_RUN)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      n_q         <= '0;
      shift_q     <= '0;
      cmp_q       <= '0;
      idx_q       <= '0;
      bad_q       <= 1'b0;
      cmp_phase_q <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      tap_o       <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          n_q         <= tap_cnt_i;
          shift_q     <= pass_m;
          cmp_q       <= cmp_m;
          idx_q       <= '0;
          bad_q       <= !n_ok;
          cmp_phase_q <= 1'b0;
          err_o       <= 1'b0;
          tap_o       <= '0;
          state_q     <= n_ok ? ST_PASS : ST_DONE;
        end
        ST_PASS, ST_CMP: begin
          shift_q <= shift_q >> 1;
          idx_q   <= idx_q + IW'(1);
          if (scan_last) state_q <= (state_q == ST_PASS) ? ST_EVAL : ST_DONE;
        end
        ST_EVAL: begin
          if (full_run) begin
            shift_q     <= cmp_q;
            idx_q       <= '0;
            cmp_phase_q <= 1'b1;
            state_q     <= ST_CMP;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          done_o  <= 1'b1;
          err_o   <= !ok;
          tap_o   <= ok ? TPW'(mid_mod) : '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_err_no_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> tap_o == '0);
  a_r3_tap_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (int'(tap_o) < int'(n_q)));
  a_r8_bad_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !n_ok) |=> state_q == ST_DONE);
  a_r9_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(n_q));
endmodule

// File: tb/tap_window_sel_bench.sv
module tap_window_sel_bench;
  localparam int M = 8;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [3:0]  tap_cnt = 0;
  logic [15:0] pass_map = 0, cmp_map = 0;
  logic        done, err;
  logic [2:0]  tap;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tap_window_sel #(.MAX_TAPS(M)) u_tap_window_sel (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tap_cnt_i(tap_cnt),
    .pass_map_i(pass_map), .cmp_map_i(cmp_map),
    .done_o(done), .err_o(err), .tap_o(tap));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input logic [15:0] p, input logic [15:0] c,
                     output bit e, output int t);
    int cyc = 0;
    @(negedge clk);
    tap_cnt = 4'(n); pass_map = p; cmp_map = c; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk(done, "R9 done seen", int'(done), 1);
    e = err; t = int'(tap);
  endtask

  task automatic expect_result(input string req, input int n, input logic [15:0] p,
                               input logic [15:0] c, input bit exp_e, input int exp_t);
    bit e; int t;
    run(n, p, c, e, t);
    chk(e == exp_e, {req, " err"}, int'(e), int'(exp_e));
    chk(t == exp_t, {req, " tap"}, t, exp_t);
  endtask

  task automatic t_reset;
    chk(!done && !err && tap == 0, "R1 reset", {29'd0, done, err, 1'b0} | int'(tap), 0);
  endtask

  task automatic t_main;
    expect_result("R5 equal runs earliest", 8, 16'h7C7C, 16'h0000, 0, 4);
    expect_result("R3 wrap modulo", 8, 16'hCFCF, 16'h0000, 0, 0);
    expect_result("R2 merge", 8, 16'hDEFE, 16'h0000, 0, 2);
  endtask

  task automatic t_min_run;
    expect_result("R6 run of 2", 8, 16'h0C0C, 16'hFFFF, 1, 0);
    expect_result("R6 run of 3", 8, 16'h1C1C, 16'h0000, 0, 3);
  endtask

  task automatic t_fallback;
    expect_result("R4 all ones", 8, 16'hFFFF, 16'hFFFF, 0, 7);
    expect_result("R7 cmp window", 8, 16'hFFFF, 16'h3838, 0, 4);
    expect_result("R7 cmp single", 8, 16'hFFFF, 16'h0404, 0, 2);
    expect_result("R7 cmp empty", 8, 16'hFFFF, 16'h0000, 1, 0);
  endtask

  task automatic t_bad_n;
    expect_result("R8 n zero", 0, 16'hFFFF, 16'hFFFF, 1, 0);
    expect_result("R8 n over max", 9, 16'hFFFF, 16'hFFFF, 1, 0);
  endtask

  task automatic t_upper_bits;
    expect_result("R10 clean", 4, 16'h00FF, 16'h0022, 0, 1);
    expect_result("R10 junk", 4, 16'hA5FF, 16'hDB22, 0, 1);
  endtask

  task automatic t_pulse_hold;
    int seen = 0;
    @(negedge clk);
    tap_cnt = 8; pass_map = 16'h7C7C; cmp_map = 0; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    pass_map = 16'h0C0C; start = 1;  // mid-run start, must be ignored
    @(negedge clk); start = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin
        seen++;
        chk(!err && tap == 4, "R9 busy start ignored", int'(tap), 4);
        @(negedge clk);
        chk(!done, "R9 single-cycle done", int'(done), 0);
        chk(tap == 4 && !err, "R9 hold", int'(tap), 4);
      end else @(negedge clk);
    end
    chk(seen == 1, "R9 one done per start", seen, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_main;
    t_min_run;
    t_fallback;
    t_bad_n;
    t_upper_bits;
    t_pulse_hold;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule